// File: doc/BRIEF.md
# DTMF Dual-Tone Generator

The block produces the two-frequency signalling tone of a telephone keypad key as a stream of digital sample words for an external DAC. A 4-bit key code picks one of four low-group (row) frequencies and one of three high-group (column) frequencies. Each tone comes from its own integer clock divider. The divider steps a 5-bit phase index through a 32-point sine table that returns 4-bit offset-binary amplitudes. The row and column amplitudes are added into a 5-bit code. Divider values are derived at elaboration from the reference clock rate (3.579545 MHz by default), so every tone lands within a fraction of a percent of its nominal pitch.

A start strobe launches one burst. The tone sounds for a fixed minimum on-time and is then silent for a fixed minimum gap. A busy flag covers both intervals. While the flag is high, strobes are ignored. The on-time and gap are given in microseconds as parameters: 93 ms each by default, or 87 ms for the alternate timing. Two enables let either tone be suppressed, so the block can send a single tone when more than one key is down. When the mode input selects pulse dialing, the output stays at its idle level of zero.

Top module: `dtmf_tone_gen`

## Requirements
- R1: Key codes map to keypad positions. Codes 1–3 use the 697 Hz row, 4–6 the 770 Hz row, 7–9 the 852 Hz row, and 10 (star), 0 and 11 (hash) the 941 Hz row. Codes 1, 4, 7 and 10 use the 1209 Hz column, codes 2, 5, 8 and 0 the 1336 Hz column, and codes 3, 6, 9 and 11 the 1477 Hz column.
- R2: Each row tone repeats every 32·D reference cycles, where D is its divider. The resulting frequency is within 0.8 % of nominal. A single tone's amplitude equals 8 only at phase index 0, which is also where every burst starts.
- R3: Each column tone meets the same 0.8 % accuracy rule and uses the same waveform encoding as R2.
- R4: The tone sounds for exactly ON = floor(CLK_HZ·TONE_US/10^6) cycles starting in the cycle after an accepted strobe. The output is 0 for the whole gap that follows.
- R5: After an accepted strobe, busy is high for exactly ON + OFF cycles, with OFF = floor(CLK_HZ·GAP_US/10^6). Busy rises only in response to an accepted strobe.
- R6: A strobe that arrives while busy is high neither restarts nor extends the burst, and it does not queue a second burst.
- R7: When tone_mode is 0 (pulse dialing), strobes are not accepted: busy stays low and the sample stays 0.
- R8: Key codes 12 to 15 are rejected: busy stays low and the sample stays 0.
- R9: row_en and col_en are latched at the strobe. A disabled tone contributes 0, so with one enable set the output carries a single tone. With both enables clear, the burst is silent but busy still follows the timing of R5.
- R10: After reset, and whenever busy is low, the sample is 0.
- R11: While a tone sounds, the sample is the sum of the row and column amplitudes (at most 30). The first sample of a dual-tone burst is 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (CLK_HZ) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle strobe requesting a burst |
| digit | input | 4 | Key code: 0–9, 10 star, 11 hash |
| tone_mode | input | 1 | 1 = tone dialing, 0 = pulse dialing (output held idle) |
| row_en | input | 1 | Enables the row tone for the next burst |
| col_en | input | 1 | Enables the column tone for the next burst |
| busy | output | 1 | High through tone-on plus the minimum gap |
| sample | output | 5 | Summed amplitude code for the DAC |

## Verification
The bench measures each of the seven frequencies from single-tone bursts. It times the distance between successive entries into code 8, which marks phase zero, so a wrong divider or a wrong key-to-row/column mapping shows up as an off-pitch reading. It counts busy cycles exactly and demands silence throughout the gap, so a counter off by one, or a tone that leaks into the gap, is caught. It strobes again in the middle of a burst, strobes in pulse mode and strobes with illegal codes. A design that restarted, queued a burst or accepted a bad code would show a changed busy length or a stray burst during the quiet window that follows.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  localparam int N_ROWS = 4;
  localparam int N_COLS = 3;
  localparam int IDX_W  = 5;
  localparam int AMP_W  = 4;
  localparam int SMP_W  = AMP_W + 1;
  localparam int KEY_W  = 4;
  localparam int LAST_KEY = 11;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_TONE = 2'd1,
    PH_GAP  = 2'd2
  } burst_phase_e;

  // nominal pitch of each low-group line
  function automatic int row_hz(input int r);
    case (r)
      0:       return 697;
      1:       return 770;
      2:       return 852;
      default: return 941;
    endcase
  endfunction

  // nominal pitch of each high-group line
  function automatic int col_hz(input int c);
    case (c)
      0:       return 1209;
      1:       return 1336;
      default: return 1477;
    endcase
  endfunction

  // rounded divider: one phase step every D clocks, 32 steps per period
  function automatic int tone_div(input int clk_hz, input int freq_hz);
    longint num;
    longint den;
    num = longint'(clk_hz) + 16 * longint'(freq_hz);
    den = 32 * longint'(freq_hz);
    return int'(num / den);
  endfunction

  // microseconds to whole clock cycles, truncated
  function automatic int us_to_cycles(input int clk_hz, input int us);
    longint prod;
    prod = longint'(clk_hz) * longint'(us);
    return int'(prod / longint'(1000000));
  endfunction

  function automatic logic key_ok(input logic [KEY_W-1:0] code);
    return code <= KEY_W'(LAST_KEY);
  endfunction

  function automatic logic [1:0] key_row(input logic [KEY_W-1:0] code);
    case (code)
      4'd1, 4'd2, 4'd3: return 2'd0;
      4'd4, 4'd5, 4'd6: return 2'd1;
      4'd7, 4'd8, 4'd9: return 2'd2;
      default:          return 2'd3;
    endcase
  endfunction

  function automatic logic [1:0] key_col(input logic [KEY_W-1:0] code);
    case (code)
      4'd1, 4'd4, 4'd7, 4'd10: return 2'd0;
      4'd2, 4'd5, 4'd8, 4'd0:  return 2'd1;
      default:                 return 2'd2;
    endcase
  endfunction

  // 32-point offset-binary sine, folded from a quarter wave
  function automatic logic [AMP_W-1:0] sine_amp(input logic [IDX_W-1:0] idx);
    logic [3:0] j;
    logic [3:0] k;
    logic [AMP_W-1:0] q;
    j = idx[3:0];
    k = (j > 4'd8) ? 4'(5'd16 - {1'b0, j}) : j;
    case (k)
      4'd0:    q = 4'd8;
      4'd1:    q = 4'd9;
      4'd2:    q = 4'd10;
      4'd3:    q = 4'd12;
      4'd4:    q = 4'd13;
      4'd5:    q = 4'd14;
      4'd6:    q = 4'd14;
      default: q = 4'd15;
    endcase
    return idx[4] ? AMP_W'(4'd15 - q) : q;
  endfunction

endpackage

// File: rtl/dtmf_tone_osc.sv
module dtmf_tone_osc #(
  parameter int DIV = 160
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic                         run,
  output logic [dtmf_pkg::IDX_W-1:0]   phase_idx
);
  localparam int CNT_W = $clog2(DIV + 1);

  logic [CNT_W-1:0] div_cnt;
  logic             step;

  assign step = run && (div_cnt == CNT_W'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt   <= '0;
      phase_idx <= '0;
    end else if (clear) begin
      div_cnt   <= '0;
      phase_idx <= '0;
    end else if (step) begin
      div_cnt   <= '0;
      phase_idx <= phase_idx + 1'b1;
    end else if (run) begin
      div_cnt   <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dtmf_burst_timer.sv
module dtmf_burst_timer #(
  parameter int ON_CYC  = 1000,
  parameter int OFF_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy,
  output logic tone_active
);
  import dtmf_pkg::*;

  localparam int LONGEST = (ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC;
  localparam int CYC_W   = $clog2(LONGEST + 1);

  burst_phase_e     phase;
  logic [CYC_W-1:0] cnt;
  logic             tone_last;
  logic             gap_last;

  assign tone_last = (cnt == CYC_W'(ON_CYC - 1));
  assign gap_last  = (cnt == CYC_W'(OFF_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (launch) phase <= PH_TONE;
        end
        PH_TONE: begin
          if (tone_last) begin
            phase <= PH_GAP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_GAP: begin
          if (gap_last) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign busy        = (phase != PH_IDLE);
  assign tone_active = (phase == PH_TONE);
endmodule

// File: rtl/dtmf_tone_gen.sv
module dtmf_tone_gen #(
  parameter int CLK_HZ  = 3579545,
  parameter int TONE_US = 93000,
  parameter int GAP_US  = 93000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [dtmf_pkg::KEY_W-1:0]   digit,
  input  logic                         tone_mode,
  input  logic                         row_en,
  input  logic                         col_en,
  output logic                         busy,
  output logic [dtmf_pkg::SMP_W-1:0]   sample
);
  import dtmf_pkg::*;

  localparam int ON_CYC  = us_to_cycles(CLK_HZ, TONE_US);
  localparam int OFF_CYC = us_to_cycles(CLK_HZ, GAP_US);

  // named internal events
  logic accept;
  logic tone_active;
  logic [31:0] tone_len_cyc;
  logic [31:0] gap_len_cyc;

  assign tone_len_cyc = 32'(ON_CYC);
  assign gap_len_cyc  = 32'(OFF_CYC);
  assign accept = start && tone_mode && key_ok(digit) && !busy;

  dtmf_burst_timer #(.ON_CYC(ON_CYC), .OFF_CYC(OFF_CYC)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (accept),
    .busy        (busy),
    .tone_active (tone_active)
  );

  // burst settings captured at the accepted strobe
  logic [1:0] row_sel;
  logic [1:0] col_sel;
  logic       row_on;
  logic       col_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_sel <= '0;
      col_sel <= '0;
      row_on  <= 1'b0;
      col_on  <= 1'b0;
    end else if (accept) begin
      row_sel <= key_row(digit);
      col_sel <= key_col(digit);
      row_on  <= row_en;
      col_on  <= col_en;
    end
  end

  logic [IDX_W-1:0] row_idx [N_ROWS];
  logic [IDX_W-1:0] col_idx [N_COLS];

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    dtmf_tone_osc #(.DIV(tone_div(CLK_HZ, row_hz(r)))) u_osc (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (accept),
      .run       (tone_active),
      .phase_idx (row_idx[r])
    );
  end

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    dtmf_tone_osc #(.DIV(tone_div(CLK_HZ, col_hz(c)))) u_osc (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (accept),
      .run       (tone_active),
      .phase_idx (col_idx[c])
    );
  end

  logic [IDX_W-1:0] row_pick;
  logic [IDX_W-1:0] col_pick;
  logic [AMP_W-1:0] row_amp;
  logic [AMP_W-1:0] col_amp;

  always_comb begin
    row_pick = '0;
    for (int r = 0; r < N_ROWS; r++) begin
      if (row_sel == 2'(r)) row_pick = row_idx[r];
    end
    col_pick = '0;
    for (int c = 0; c < N_COLS; c++) begin
      if (col_sel == 2'(c)) col_pick = col_idx[c];
    end
  end

  assign row_amp = row_on ? sine_amp(row_pick) : '0;
  assign col_amp = col_on ? sine_amp(col_pick) : '0;
  assign sample  = tone_active ? (SMP_W'(row_amp) + SMP_W'(col_amp)) : '0;
endmodule

// File: rtl/dtmf_tone_gen_chk.sv
module dtmf_tone_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [3:0]  digit,
  input logic        tone_mode,
  input logic        busy,
  input logic [4:0]  sample,
  input logic        accept,
  input logic [31:0] tone_len,
  input logic [31:0] gap_len
);
  logic [31:0] elapsed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      elapsed <= '0;
    else if (accept)                 elapsed <= 32'd1;
    else if (busy && elapsed != '0)  elapsed <= elapsed + 32'd1;
    else                             elapsed <= '0;
  end

  assert_tone_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && elapsed > tone_len) |-> (sample == '0));

  assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(elapsed) == tone_len + gap_len));

  assert_busy_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start && tone_mode && digit <= 4'd11));

  assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && elapsed != '0) |=> (!busy || elapsed == $past(elapsed) + 32'd1));

  assert_pulse_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tone_mode && !busy) |=> !busy);

  assert_bad_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && digit > 4'd11 && !busy) |=> !busy);

  assert_idle_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sample == '0));

  assert_sum_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sample <= 5'd30);
endmodule

bind dtmf_tone_gen dtmf_tone_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .digit     (digit),
  .tone_mode (tone_mode),
  .busy      (busy),
  .sample    (sample),
  .accept    (accept),
  .tone_len  (tone_len_cyc),
  .gap_len   (gap_len_cyc)
);

// File: tb/dtmf_tone_gen_bench.sv
module dtmf_tone_gen_bench;
  localparam int CLK_HZ  = 3579545;
  localparam int TONE_US = 3000;
  localparam int GAP_US  = 500;
  localparam int ON_EXP  = int'((longint'(CLK_HZ) * longint'(TONE_US)) / longint'(1000000));
  localparam int OFF_EXP = int'((longint'(CLK_HZ) * longint'(GAP_US)) / longint'(1000000));

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] digit = 4'd0;
  logic       tone_mode = 1'b1;
  logic       row_en = 1'b1;
  logic       col_en = 1'b1;
  logic       busy;
  logic [4:0] sample;

  dtmf_tone_gen #(.CLK_HZ(CLK_HZ), .TONE_US(TONE_US), .GAP_US(GAP_US)) u_dtmf_tone_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .digit(digit), .tone_mode(tone_mode),
    .row_en(row_en), .col_en(col_en), .busy(busy), .sample(sample)
  );

  typedef struct {
    bit    accept;
    int    first;
    real   nom;
    string req;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0;
  int n_err = 0;
  int n_sent = 0;
  int n_done = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic wait_done();
    while (n_done != n_sent) @(negedge clk);
  endtask

  // driver: queue the expectation, then strobe
  task automatic send(input logic [3:0] d, input bit tm, input bit ren, input bit cen,
                      input bit acc, input int first, input real nom, input string req,
                      input int poke);
    exp_t it;
    @(negedge clk);
    digit = d; tone_mode = tm; row_en = ren; col_en = cen;
    it.accept = acc; it.first = first; it.nom = nom; it.req = req;
    sb.push_back(it);
    n_sent++;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke > 0) begin
      repeat (poke) @(negedge clk);
      digit = 4'd3; row_en = 1'b1; col_en = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done();
    tone_mode = 1'b1;
  endtask

  task automatic quiet(input string req);
    exp_t it;
    it.accept = 1'b0; it.first = 0; it.nom = 0.0; it.req = req;
    sb.push_back(it);
    n_sent++;
    wait_done();
  endtask

  // monitor: pop expectations and measure what the design produces
  initial begin : monitor
    exp_t it;
    int   k, wait_cnt, late, last_nz, n_ent, t1, t2, bad_b, bad_s;
    int   prev;
    real  f;
    forever begin
      while (sb.size() == 0) @(negedge clk);
      it = sb.pop_front();
      if (it.accept) begin
        wait_cnt = 0;
        while (!busy && wait_cnt < 20) begin
          @(negedge clk);
          wait_cnt++;
        end
        check(busy, it.req, "burst started", int'(busy), 1);
        if (busy) begin
          k = 1; late = 0; last_nz = 0; n_ent = 0; t1 = 0; t2 = 0;
          check(int'(sample) == it.first, it.req, "first sample", int'(sample), it.first);
          if (sample != 0) last_nz = 1;
          if (sample == 5'd8) begin n_ent = 1; t1 = 1; end
          prev = int'(sample);
          forever begin
            @(negedge clk);
            if (!busy) break;
            k++;
            if (k > ON_EXP && sample != 0) late++;
            if (k <= ON_EXP && sample != 0) last_nz = k;
            if (sample == 5'd8 && prev != 8 && k <= ON_EXP) begin
              if (n_ent == 0) t1 = k;
              else if (n_ent == 1) t2 = k;
              n_ent++;
            end
            prev = int'(sample);
          end
          check(k == ON_EXP + OFF_EXP, "R5", "busy cycles", k, ON_EXP + OFF_EXP);
          check(late == 0, "R4", "nonzero samples in gap", late, 0);
          if (it.first != 0)
            check(last_nz > ON_EXP - 500, "R4", "tone still sounding near end of on-time", last_nz, ON_EXP);
          if (it.nom > 0.0) begin
            check(n_ent >= 2, it.req, "phase-zero entries", n_ent, 2);
            if (n_ent >= 2) begin
              f = real'(CLK_HZ) / real'(t2 - t1);
              n_chk++;
              if (!(f > it.nom * 0.992 && f < it.nom * 1.008)) begin
                n_err++;
                $display("FAIL %s frequency: actual=%0.1f Hz expected=%0.1f Hz", it.req, f, it.nom);
              end
            end
          end
        end
      end else begin
        bad_b = 0; bad_s = 0;
        repeat (40) begin
          @(negedge clk);
          if (busy) bad_b++;
          if (sample != 0) bad_s++;
        end
        check(bad_b == 0, it.req, "busy cycles while quiet", bad_b, 0);
        check(bad_s == 0, it.req, "nonzero samples while quiet", bad_s, 0);
      end
      n_done++;
    end
  end

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin : stimulus
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R10", "busy after reset", int'(busy), 0);
    check(sample == 5'd0, "R10", "sample after reset", int'(sample), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1/R2: row tones via single-tone bursts
    send(4'd1,  1'b1, 1'b1, 1'b0, 1'b1, 8, 697.0, "R1/R2", 0);
    send(4'd4,  1'b1, 1'b1, 1'b0, 1'b1, 8, 770.0, "R1/R2", 0);
    send(4'd7,  1'b1, 1'b1, 1'b0, 1'b1, 8, 852.0, "R1/R2", 0);
    send(4'd10, 1'b1, 1'b1, 1'b0, 1'b1, 8, 941.0, "R1/R2", 0);
    // R1/R3: column tones
    send(4'd1,  1'b1, 1'b0, 1'b1, 1'b1, 8, 1209.0, "R1/R3", 0);
    send(4'd0,  1'b1, 1'b0, 1'b1, 1'b1, 8, 1336.0, "R1/R3", 0);
    send(4'd11, 1'b1, 1'b0, 1'b1, 1'b1, 8, 1477.0, "R1/R3", 0);
    // R11: dual tone sum
    send(4'd5,  1'b1, 1'b1, 1'b1, 1'b1, 16, 0.0, "R11", 0);
    // R9: both tones suppressed, timing kept
    send(4'd2,  1'b1, 1'b0, 1'b0, 1'b1, 0, 0.0, "R9", 0);
    // R7: pulse mode
    send(4'd5,  1'b0, 1'b1, 1'b1, 1'b0, 0, 0.0, "R7", 0);
    // R8: illegal codes
    send(4'd12, 1'b1, 1'b1, 1'b1, 1'b0, 0, 0.0, "R8", 0);
    send(4'd15, 1'b1, 1'b1, 1'b1, 1'b0, 0, 0.0, "R8", 0);
    // R6: strobe during busy neither restarts nor queues
    send(4'd8,  1'b1, 1'b1, 1'b1, 1'b1, 16, 0.0, "R6", 100);
    quiet("R6");
    summary();
  end
endmodule